// File: doc/BRIEF.md
# Disk Controller Processor I/O Instruction Interface

This block sits between a 12-bit processor's I/O instruction pulses and the sequencer of a floppy disk controller. On each I/O instruction it decodes a 3-bit operation code and takes a 12-bit accumulator value. It then updates its control and data registers, sets or clears its flags, and answers the processor with a skip indication and a returned accumulator value, in the same cycle.

The block keeps the control word, the data buffer word, three skip-testable flags (transfer ready, error, done) and an interrupt enable. It tells the sequencer, with single-cycle pulses, when a command has started, when a data word has been exchanged, when the sector buffer pointer must return to zero, and when an initialize was requested. The sequencer reports back through busy and transfer-phase levels and through flag-set and data-write strobes.

For hosts that move only 8 bits at a time, an extended mode loads a command in two transfers. The first transfer holds the low byte and raises transfer ready. The second transfer supplies the upper control nibble and starts the command.

Top module: `dkio_iot_if`

## Requirements
- R1: After synchronous reset the control word and data word read 0, irq is 0, all three skip tests return skip 0, and no output pulse is active.
- R2: Operation code 1 (load command), when neither seq_busy nor a pending split load is present, copies ac_in into the control word and the data word, clears transfer ready, error and done, returns ac_out = 0, and pulses bptr_clr and cmd_start in the following cycle. Control word layout: function bits 3:1, drive select bit 4, 8-bit mode bit 6, maintenance bit 7, density bit 8.
- R3: A load command that arrives while seq_busy is high or a split load is pending changes no register or flag, returns ac_out = ac_in, and gives no pulse.
- R4: Codes 3, 4 and 5 test transfer ready, error and done in that order: skip is 1 exactly when the tested flag is set, and that flag is clear afterwards. ac_out equals ac_in.
- R5: Code 6 sets the interrupt enable to ac_in bit 0, and irq is high exactly while done and the enable are both set.
- R6: Code 7 clears the control word, the data word, all flags, the enable and any pending split load, and pulses init_req in the next cycle.
- R7: With ext_en high, a load command with ac_in bit 6 set stores only ac_in[7:0] (upper control bits zero), sets transfer ready and gives no cmd_start. The next code 2 writes ac_in[3:0] into control bits 11:8 and ac_in[7:0] into the data word, then pulses cmd_start. With ext_en low, bit 6 does not split the load.
- R8: Code 2 while seq_xfer = 1 (accept) writes ac_in into the data word, returns ac_out = ac_in and pulses data_strobe.
- R9: Code 2 while seq_xfer is 0 (none) or 2 (supply) returns the data word when control bit 6 is 0, and ac_in OR the data word's low 8 bits when control bit 6 is 1. Only the supply phase pulses data_strobe.
- R10: seq_set_tr, seq_set_err and seq_set_done set their flags, and a set takes priority over a skip test that clears the flag in the same cycle. seq_dbr_we loads seq_dbr into the data word.
- R11: Code 0 changes nothing, returns ac_out = ac_in and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_en | input | 1 | Allows the split 8-bit command load |
| iot_valid | input | 1 | I/O instruction present this cycle |
| iot_code | input | 3 | Operation code of the instruction |
| ac_in | input | 12 | Accumulator value from the processor |
| ac_out | output | 12 | Accumulator value returned to the processor |
| skip | output | 1 | Skip request to the processor |
| seq_busy | input | 1 | Sequencer is executing a command |
| seq_xfer | input | 2 | Sequencer transfer phase: 0 none, 1 accept, 2 supply |
| seq_set_tr | input | 1 | Sequencer sets transfer ready |
| seq_set_err | input | 1 | Sequencer sets error |
| seq_set_done | input | 1 | Sequencer sets done |
| seq_dbr_we | input | 1 | Sequencer writes the data word |
| seq_dbr | input | 12 | Data word value from the sequencer |
| csr_out | output | 12 | Control word |
| dbr_out | output | 12 | Data word |
| cmd_start | output | 1 | Pulse: command begins |
| data_strobe | output | 1 | Pulse: data word exchanged |
| bptr_clr | output | 1 | Pulse: return buffer pointer to zero |
| init_req | output | 1 | Pulse: initialize requested |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the pending half of a split load. It exists only after a load command that has extended mode enabled and bit 6 set. The bench reaches it with a sweep over every low byte that has bit 6 set, and at each byte it proves three things: a second load is refused, transfer ready was raised, and the following exchange joins the nibble and the byte into the control word. A second hard case is a flag set by the sequencer in the same cycle as a skip test that clears it. The bench holds the set strobe through the skip instruction to produce it.

// File: rtl/dkio_pkg.sv
// Package: shared codes and positions for the disk I/O instruction interface.
// Assumes a 3-bit operation code and three skip-testable flags.
package dkio_pkg;
    localparam int PULSE_W  = 3;
    localparam int NFLAG    = 3;
    localparam int FL_TR    = 0;
    localparam int FL_ERR   = 1;
    localparam int FL_DONE  = 2;
    localparam int MODE_BIT = 6;
    localparam int BYTE_W   = 8;

    typedef enum logic [PULSE_W-1:0] {
        OP_NONE = 3'd0,
        OP_LOAD = 3'd1,
        OP_XCHG = 3'd2,
        OP_SKTR = 3'd3,
        OP_SKER = 3'd4,
        OP_SKDN = 3'd5,
        OP_IEN  = 3'd6,
        OP_INIT = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        XF_NONE   = 2'd0,
        XF_ACCEPT = 2'd1,
        XF_SUPPLY = 2'd2
    } xfer_e;
endpackage

// File: rtl/dkio_decode.sv
// Module: one-hot decode of the operation code.
// Assumes code_i is meaningful only while valid_i is high.
module dkio_decode #(
    parameter int PULSE_W = 3,
    localparam int NCODE = 1 << PULSE_W
) (
    input  logic               valid_i,
    input  logic [PULSE_W-1:0] code_i,
    output logic [NCODE-1:0]   hit_o
);
    // one comparator per code
    for (genvar k = 0; k < NCODE; k++) begin : g_hit
        assign hit_o[k] = valid_i && (code_i == PULSE_W'(k));
    end
endmodule

// File: rtl/dkio_flag.sv
// Module: one skip-testable flag. A set beats a clear in the same cycle.
// Assumes test_i is a single-cycle instruction strobe.
module dkio_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic test_i,
    input  logic clr_i,
    output logic q_o,
    output logic skip_o
);
    // flag register: set, else clear on test or bulk clear
    always_ff @(posedge clk) begin
        if (!rst_n)               q_o <= 1'b0;
        else if (set_i)           q_o <= 1'b1;
        else if (test_i || clr_i) q_o <= 1'b0;
    end

    assign skip_o = test_i && q_o;

    p_skip_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_o && !set_i) |=> !q_o);
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
endmodule

// File: rtl/dkio_regs.sv
// Module: control word, data word, split-load state and sequencer pulses.
// Assumes hit_* are one-hot decoded instruction strobes.
module dkio_regs
    import dkio_pkg::*;
#(
    parameter int WORD_W = 12,
    localparam int HI_W = WORD_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_en,
    input  logic              hit_load,
    input  logic              hit_xchg,
    input  logic              hit_init,
    input  logic              seq_busy,
    input  logic [1:0]        seq_xfer,
    input  logic              seq_dbr_we,
    input  logic [WORD_W-1:0] seq_dbr,
    input  logic [WORD_W-1:0] ac_in,
    output logic [WORD_W-1:0] csr_o,
    output logic [WORD_W-1:0] dbr_o,
    output logic              lcd_ok_o,
    output logic              ext_load_o,
    output logic              rd_dbr_o,
    output logic              cmd_start_o,
    output logic              data_strobe_o,
    output logic              bptr_clr_o,
    output logic              init_req_o
);
    logic pend_q;
    logic second, acc_wr, supply;
    logic [WORD_W-1:0] ac_low;

    assign ac_low     = {{HI_W{1'b0}}, ac_in[BYTE_W-1:0]};
    assign lcd_ok_o   = hit_load && !seq_busy && !pend_q;
    assign ext_load_o = lcd_ok_o && ext_en && ac_in[MODE_BIT];
    assign second     = hit_xchg && pend_q;
    assign acc_wr     = hit_xchg && !pend_q && (seq_xfer == XF_ACCEPT);
    assign supply     = hit_xchg && !pend_q && (seq_xfer == XF_SUPPLY);
    assign rd_dbr_o   = hit_xchg && !pend_q && (seq_xfer != XF_ACCEPT);

    // register update: initialize, command load, split second half, data writes
    always_ff @(posedge clk) begin
        if (!rst_n || hit_init) begin
            csr_o         <= '0;
            dbr_o         <= '0;
            pend_q        <= 1'b0;
            cmd_start_o   <= 1'b0;
            data_strobe_o <= 1'b0;
            bptr_clr_o    <= 1'b0;
        end else begin
            cmd_start_o   <= (lcd_ok_o && !ext_load_o) || second;
            data_strobe_o <= acc_wr || supply;
            bptr_clr_o    <= lcd_ok_o;
            if (lcd_ok_o) begin
                csr_o  <= ext_load_o ? ac_low : ac_in;
                dbr_o  <= ext_load_o ? ac_low : ac_in;
                pend_q <= ext_load_o;
            end
            if (second) begin
                csr_o[WORD_W-1:BYTE_W] <= ac_in[HI_W-1:0];
                dbr_o                  <= ac_low;
                pend_q                 <= 1'b0;
            end
            if (acc_wr)     dbr_o <= ac_in;
            if (seq_dbr_we) dbr_o <= seq_dbr;
        end
    end

    // initialize request pulse
    always_ff @(posedge clk) begin
        init_req_o <= rst_n && hit_init;
    end

    p_start_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o |-> $past(hit_load || hit_xchg));
    p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_load && (seq_busy || pend_q) && !hit_init) |=> $stable(csr_o));
    p_init_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_init |=> (csr_o == '0) && (dbr_o == '0) && !pend_q && init_req_o);
    p_split_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_load_o |=> (!cmd_start_o && pend_q));
endmodule

// File: rtl/dkio_iot_if.sv
// Module: top of the disk controller I/O instruction interface.
// Assumes the processor samples ac_out and skip in the instruction cycle.
module dkio_iot_if
    import dkio_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_en,
    input  logic              iot_valid,
    input  logic [2:0]        iot_code,
    input  logic [WORD_W-1:0] ac_in,
    output logic [WORD_W-1:0] ac_out,
    output logic              skip,
    input  logic              seq_busy,
    input  logic [1:0]        seq_xfer,
    input  logic              seq_set_tr,
    input  logic              seq_set_err,
    input  logic              seq_set_done,
    input  logic              seq_dbr_we,
    input  logic [WORD_W-1:0] seq_dbr,
    output logic [WORD_W-1:0] csr_out,
    output logic [WORD_W-1:0] dbr_out,
    output logic              cmd_start,
    output logic              data_strobe,
    output logic              bptr_clr,
    output logic              init_req,
    output logic              irq
);
    localparam int NCODE = 1 << PULSE_W;

    logic [NCODE-1:0] hit;
    logic [NFLAG-1:0] f_set, f_q, f_skip;
    logic lcd_ok, ext_load, rd_dbr, ie_q, f_clr;

    dkio_decode #(.PULSE_W(PULSE_W)) u_decode (
        .valid_i(iot_valid), .code_i(iot_code), .hit_o(hit));

    dkio_regs #(.WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en),
        .hit_load(hit[OP_LOAD]), .hit_xchg(hit[OP_XCHG]), .hit_init(hit[OP_INIT]),
        .seq_busy(seq_busy), .seq_xfer(seq_xfer),
        .seq_dbr_we(seq_dbr_we), .seq_dbr(seq_dbr), .ac_in(ac_in),
        .csr_o(csr_out), .dbr_o(dbr_out), .lcd_ok_o(lcd_ok),
        .ext_load_o(ext_load), .rd_dbr_o(rd_dbr),
        .cmd_start_o(cmd_start), .data_strobe_o(data_strobe),
        .bptr_clr_o(bptr_clr), .init_req_o(init_req));

    assign f_set[FL_TR]   = seq_set_tr || ext_load;
    assign f_set[FL_ERR]  = seq_set_err;
    assign f_set[FL_DONE] = seq_set_done;
    assign f_clr          = lcd_ok || hit[OP_INIT];

    // one flag cell per skip test; test codes follow the flag order
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        dkio_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(f_set[g]),
            .test_i(hit[int'(OP_SKTR) + g]), .clr_i(f_clr),
            .q_o(f_q[g]), .skip_o(f_skip[g]));
    end

    // interrupt enable from accumulator bit 0, cleared by initialize
    always_ff @(posedge clk) begin
        if (!rst_n || hit[OP_INIT]) ie_q <= 1'b0;
        else if (hit[OP_IEN])       ie_q <= ac_in[0];
    end

    assign irq  = f_q[FL_DONE] && ie_q;
    assign skip = |f_skip;

    // returned accumulator: cleared on accepted load, data word on read
    always_comb begin
        if (lcd_ok)
            ac_out = '0;
        else if (rd_dbr && csr_out[MODE_BIT])
            ac_out = ac_in | {{(WORD_W-BYTE_W){1'b0}}, dbr_out[BYTE_W-1:0]};
        else if (rd_dbr)
            ac_out = dbr_out;
        else
            ac_out = ac_in;
    end

    p_skip_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (iot_valid && (|f_q)));
    p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[OP_IEN] && f_q[FL_DONE] && !lcd_ok) |=> (irq == $past(ac_in[0])));
    p_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[OP_NONE] && !seq_dbr_we) |=> ($stable(csr_out) && $stable(dbr_out) && !cmd_start));
endmodule

// File: tb/test_dkio_iot_if.sv
module test_dkio_iot_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_en = 1'b0;
    logic iot_valid = 1'b0;
    logic [2:0] iot_code = '0;
    logic [11:0] ac_in = '0;
    logic [11:0] ac_out;
    logic skip;
    logic seq_busy = 1'b0;
    logic [1:0] seq_xfer = 2'd0;
    logic seq_set_tr = 1'b0, seq_set_err = 1'b0, seq_set_done = 1'b0;
    logic seq_dbr_we = 1'b0;
    logic [11:0] seq_dbr = '0;
    logic [11:0] csr_out, dbr_out;
    logic cmd_start, data_strobe, bptr_clr, init_req, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [11:0] r_ac;
    logic r_skip, r_start, r_strobe, r_bclr, r_init;

    always #4 clk = ~clk;

    dkio_iot_if i_dkio_iot_if (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .iot_valid(iot_valid),
        .iot_code(iot_code), .ac_in(ac_in), .ac_out(ac_out), .skip(skip),
        .seq_busy(seq_busy), .seq_xfer(seq_xfer), .seq_set_tr(seq_set_tr),
        .seq_set_err(seq_set_err), .seq_set_done(seq_set_done),
        .seq_dbr_we(seq_dbr_we), .seq_dbr(seq_dbr), .csr_out(csr_out),
        .dbr_out(dbr_out), .cmd_start(cmd_start), .data_strobe(data_strobe),
        .bptr_clr(bptr_clr), .init_req(init_req), .irq(irq));

    task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one instruction: drive at falling edge, combinational reply sampled 1 ns later,
    // registered pulses sampled at the next falling edge
    task automatic iot(input logic [2:0] code, input logic [11:0] a);
        iot_valid = 1'b1; iot_code = code; ac_in = a;
        #1;
        r_ac = ac_out; r_skip = skip;
        @(posedge clk); @(negedge clk);
        r_start = cmd_start; r_strobe = data_strobe; r_bclr = bptr_clr; r_init = init_req;
        iot_valid = 1'b0; iot_code = '0; ac_in = '0;
    endtask

    task automatic seqp(input bit t, input bit e, input bit d);
        seq_set_tr = t; seq_set_err = e; seq_set_done = d;
        @(posedge clk); @(negedge clk);
        seq_set_tr = 0; seq_set_err = 0; seq_set_done = 0;
    endtask

    task automatic seq_wr(input logic [11:0] d);
        seq_dbr_we = 1'b1; seq_dbr = d;
        @(posedge clk); @(negedge clk);
        seq_dbr_we = 1'b0;
    endtask

    task automatic drain_flags();
        iot(3'd3, 0); iot(3'd4, 0); iot(3'd5, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(csr_out == 0, "R1 csr", csr_out, 0);
        chk(dbr_out == 0, "R1 dbr", dbr_out, 0);
        chk(irq == 0, "R1 irq", {11'd0, irq}, 0);
        chk(!cmd_start && !data_strobe && !bptr_clr && !init_req, "R1 pulses", {8'd0, cmd_start, data_strobe, bptr_clr, init_req}, 0);
        for (int t = 3; t <= 5; t++) begin
            iot(3'(t), 12'h0F0);
            chk(r_skip == 0, "R1 skip", {11'd0, r_skip}, 0);
        end

        // R2 sweep of every control word, non-split
        for (int a = 0; a < 4096; a++) begin
            iot(3'd1, 12'(a));
            chk(r_ac == 0 && r_start && r_bclr, "R2 load reply", r_ac, 0);
            chk(csr_out == 12'(a) && dbr_out == 12'(a), "R2 words", csr_out, 12'(a));
        end
        // R7 with ext_en low, bit 6 does not split
        iot(3'd1, 12'hE55);
        chk(r_start == 1 && csr_out == 12'hE55, "R7 no split when disabled", csr_out, 12'hE55);
        // R2 load clears flags
        seqp(1, 1, 1);
        iot(3'd1, 12'h006);
        drain_flags();
        chk(r_skip == 0, "R2 done cleared", {11'd0, r_skip}, 0);
        iot(3'd3, 0);
        chk(r_skip == 0, "R2 tr cleared", {11'd0, r_skip}, 0);

        // R4 / R10 each flag, each test
        for (int fl = 0; fl < 3; fl++) begin
            seqp(fl == 0, fl == 1, fl == 2);
            for (int t = 0; t < 3; t++) begin
                iot(3'(3 + t), 12'(100 + t));
                chk(r_skip == (t == fl), "R4 skip matches flag", {11'd0, r_skip}, {11'd0, t == fl});
                chk(r_ac == 12'(100 + t), "R4 ac passthrough", r_ac, 12'(100 + t));
            end
            iot(3'(3 + fl), 0);
            chk(r_skip == 0, "R4 flag cleared by test", {11'd0, r_skip}, 0);
        end
        // R10 set beats clear
        seqp(1, 0, 0);
        seq_set_tr = 1'b1;
        iot(3'd3, 0);
        seq_set_tr = 1'b0;
        chk(r_skip == 1, "R10 skip with set", {11'd0, r_skip}, 1);
        iot(3'd3, 0);
        chk(r_skip == 1, "R10 set kept flag", {11'd0, r_skip}, 1);
        iot(3'd3, 0);
        chk(r_skip == 0, "R10 cleared afterwards", {11'd0, r_skip}, 0);

        // R5 interrupt enable
        iot(3'd6, 12'h001);
        chk(irq == 0, "R5 no done no irq", {11'd0, irq}, 0);
        seqp(0, 0, 1);
        chk(irq == 1, "R5 irq", {11'd0, irq}, 1);
        iot(3'd6, 12'hFFE);
        chk(irq == 0, "R5 bit0 low disables", {11'd0, irq}, 0);
        iot(3'd6, 12'h001);
        chk(irq == 1, "R5 re-enable", {11'd0, irq}, 1);
        iot(3'd5, 0);
        chk(r_skip == 1 && irq == 0, "R5 done test drops irq", {11'd0, irq}, 0);

        // R3 busy refuses load
        iot(3'd1, 12'h321);
        seqp(0, 0, 1);
        seq_busy = 1'b1;
        iot(3'd1, 12'h5A5);
        chk(r_ac == 12'h5A5, "R3 ac returned", r_ac, 12'h5A5);
        chk(csr_out == 12'h321 && !r_start && !r_bclr, "R3 csr kept", csr_out, 12'h321);
        seq_busy = 1'b0;
        iot(3'd5, 0);
        chk(r_skip == 1, "R3 done kept", {11'd0, r_skip}, 1);

        // R11 code 0
        seqp(1, 0, 0);
        iot(3'd0, 12'h777);
        chk(r_ac == 12'h777 && csr_out == 12'h321 && !r_start && !r_strobe, "R11 nop", r_ac, 12'h777);
        iot(3'd3, 0);
        chk(r_skip == 1, "R11 flag kept", {11'd0, r_skip}, 1);

        // R8 accept sweep
        seq_xfer = 2'd1;
        for (int v = 0; v < 4096; v += 37) begin
            iot(3'd2, 12'(v));
            chk(dbr_out == 12'(v) && r_strobe && r_ac == 12'(v), "R8 accept", dbr_out, 12'(v));
        end

        // R9 read back in 12-bit mode then 8-bit mode
        iot(3'd1, 12'h004);
        for (int m = 0; m < 2; m++) begin
            if (m == 1) iot(3'd1, 12'h042);
            for (int v = 0; v < 4096; v += 91) begin
                logic [11:0] d, a, e;
                d = 12'(v * 7 + 5); a = 12'(v ^ 12'hA30);
                e = (m == 1) ? (a | {4'd0, d[7:0]}) : d;
                seq_wr(d);
                seq_xfer = 2'd2;
                iot(3'd2, a);
                chk(r_ac == e && r_strobe == 1, "R9 supply read", r_ac, e);
                chk(dbr_out == d, "R9 supply keeps data", dbr_out, d);
                seq_xfer = 2'd0;
                iot(3'd2, a);
                chk(r_ac == e && r_strobe == 0, "R9 plain read", r_ac, e);
            end
        end

        // R7 split load sweep over low bytes with bit 6 set
        ext_en = 1'b1;
        for (int lo = 0; lo < 256; lo++) begin
            if (lo[6]) begin
                logic [3:0] nib;
                logic [11:0] a2;
                nib = 4'(lo) ^ 4'hA;
                a2 = {4'h7, 4'(lo >> 4), nib};
                iot(3'd1, {4'h5, 8'(lo)});
                chk(r_ac == 0 && r_start == 0 && csr_out == 12'(lo), "R7 first half", csr_out, 12'(lo));
                iot(3'd1, 12'h123);
                chk(r_ac == 12'h123 && csr_out == 12'(lo), "R3 pending refuses load", csr_out, 12'(lo));
                iot(3'd3, 0);
                chk(r_skip == 1, "R7 tr raised", {11'd0, r_skip}, 1);
                iot(3'd2, a2);
                chk(r_start == 1 && csr_out == {nib, 8'(lo)}, "R7 second half csr", csr_out, {nib, 8'(lo)});
                chk(dbr_out == {4'd0, a2[7:0]}, "R7 second half dbr", dbr_out, {4'd0, a2[7:0]});
            end
        end

        // R6 initialize, also from pending split
        seqp(1, 1, 1);
        iot(3'd6, 12'h001);
        iot(3'd1, 12'h0C3);
        iot(3'd6, 12'h001);
        iot(3'd7, 12'h000);
        chk(r_init == 1, "R6 init pulse", {11'd0, r_init}, 1);
        chk(csr_out == 0 && dbr_out == 0 && irq == 0, "R6 words cleared", csr_out, 0);
        iot(3'd3, 0);
        chk(r_skip == 0, "R6 tr cleared", {11'd0, r_skip}, 0);
        iot(3'd4, 0);
        chk(r_skip == 0, "R6 err cleared", {11'd0, r_skip}, 0);
        seqp(0, 0, 1);
        chk(irq == 0, "R6 enable cleared", {11'd0, irq}, 0);
        ext_en = 1'b0;
        iot(3'd1, 12'h0C3);
        chk(r_start == 1, "R6 pending cleared", {11'd0, r_start}, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule